// File: doc/BRIEF.md
# Per-Colour Dark-Level Offset Corrector

This block sits after the digitiser of a three-colour linear image sensor. Each input sample arrives with a colour code and two region flags. One flag marks the shielded (optical-black) pixels at the start of a line. The other marks the active pixels that carry image data. While the black region is running, the block builds a separate dark-level estimate for red, green and blue. Each active sample then has its own colour's estimate subtracted, and the result goes out with the colour code unchanged.

The sensor's three channels do not share one dark level, so a single global offset leaves a colour cast. Because each sample carries its own tag, the block handles both ways of reading the sensor. In the interleaved way, red, green and blue samples alternate within every pixel period. In the other way, a whole line is read in one colour. Parameters choose the sample width and the number of black pixels per line. A parameter selects how the average is formed: an exact divide by the black-pixel count done with a reciprocal multiply, or a shift over the largest power of two below that count. Another parameter enables a leaky update that moves the stored offset one eighth of the way toward each new measurement.

Top module: `ob_offset_corr`

## Requirements
- R1: After reset, `out_vld` and `out_dat` are 0 and all three stored offsets are 0, so active samples seen before any black region leave the block unchanged.
- R2: The colour code is 0 for red, 1 for green and 2 for blue. Code 3 is unused: a sample carrying it produces no output and adds nothing to any estimate.
- R3: A sample with `in_vld` and `in_ob` high adds its value to its colour's running sum and produces no output. Only the first TAKE black samples of each colour per line count. TAKE is OB_N when AVG_MODE=0 and the largest power of two below OB_N when AVG_MODE=1.
- R4: With AVG_MODE=0, a colour's new estimate is floor(sum / OB_N). With the default OB_N of 48, this is the floor of the sum of its 48 black samples divided by 48.
- R5: With AVG_MODE=1, a colour's new estimate is floor(sum / TAKE). With OB_N=48 this is the sum of the first 32 black samples divided by 32, and any later black samples are ignored.
- R6: New estimates take effect on the first `in_vld` sample with `in_ob` low after at least one black sample has been accepted. That sample and all later ones use them, and the sums then restart. A colour that received no black samples in that region keeps its previous offset.
- R7: For an active sample, `out_dat` = max(in_dat − offset[colour], 0), presented one clock after the input.
- R8: `out_vld` is high exactly one clock after an input with `in_vld` high, `in_ob` low, `in_act` high and a colour code of 0 to 2. Dummy and invalid samples (with `in_act` low) are dropped.
- R9: `out_col` equals the colour code of the sample that produced the output, so the output keeps the input order and tags.
- R10: With LEAKY=1, the stored offset becomes old + floor((estimate − old) / 8) instead of the estimate itself.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_vld | input | 1 | Input sample strobe |
| in_col | input | 2 | Colour code: 0 red, 1 green, 2 blue, 3 unused |
| in_ob | input | 1 | Sample belongs to the optical-black region |
| in_act | input | 1 | Sample is an active image pixel |
| in_dat | input | DW | Digitised sample value |
| out_vld | output | 1 | Corrected sample strobe |
| out_col | output | 2 | Colour code of the corrected sample |
| out_dat | output | DW | Offset-corrected, zero-clamped value |

## Verification
Lines are driven in two patterns: red, green and blue interleaved within each pixel, and whole lines in a single colour. The interleaved pattern shows whether the three offsets are kept apart. The single-colour pattern shows whether colours without black samples keep their old offsets. Each line's dark levels differ from the line before, so using a stale offset shows up on the first active sample. Some active values sit below the dark level, which exercises the zero clamp. Samples with colour code 3, gaps and dummy pixels are mixed in to check that they are dropped. The default instance and a second one with shift averaging and the leaky update run side by side, which separates the exact divide, the truncated sum and the blend.

// File: rtl/ob_offset_corr.sv
module ob_offset_corr #(
  parameter int DW       = 12,
  parameter int OB_N     = 48,
  parameter int AVG_MODE = 0,
  parameter int LEAKY    = 0
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          in_vld,
  input  logic [1:0]    in_col,
  input  logic          in_ob,
  input  logic          in_act,
  input  logic [DW-1:0] in_dat,
  output logic          out_vld,
  output logic [1:0]    out_col,
  output logic [DW-1:0] out_dat
);
  localparam int CW    = $clog2(OB_N + 1);
  localparam int P2LOG = $clog2(OB_N) - 1;
  localparam int TAKE  = AVG_MODE != 0 ? (1 << P2LOG) : OB_N;
  localparam int AW    = DW + CW;
  localparam int SH    = DW + 2 * CW + 1;
  localparam int PW    = AW + SH;
  localparam longint RECIP = ((64'd1 << SH) + OB_N - 1) / OB_N;

  logic [AW-1:0] acc [3];
  logic [CW-1:0] cnt [3];
  logic [DW-1:0] off [3];
  logic [DW-1:0] nxt [3];
  logic          seen;
  logic [DW-1:0] cur_off;
  logic          cur_upd;
  logic [DW:0]   diff;

  wire is_col  = in_col != 2'd3;
  wire take_ob = in_vld && in_ob && is_col;
  wire commit  = in_vld && !in_ob && seen;

  for (genvar g = 0; g < 3; g++) begin : g_col
    logic [DW-1:0] avg;
    if (AVG_MODE != 0) begin : g_shift
      assign avg = DW'(acc[g] >> P2LOG);
    end else begin : g_recip
      logic [PW-1:0] prod;
      assign prod = PW'(acc[g]) * PW'(RECIP);
      assign avg  = DW'(prod >> SH);
    end
    if (LEAKY != 0) begin : g_leak
      logic signed [DW+1:0] d;
      logic signed [DW+1:0] s;
      assign d = $signed({2'b00, avg}) - $signed({2'b00, off[g]});
      assign s = $signed({2'b00, off[g]}) + (d >>> 3);
      assign nxt[g] = s[DW-1:0];
    end else begin : g_direct
      assign nxt[g] = avg;
    end

    always_ff @(posedge clk) begin
      if (!rst_n) begin
        acc[g] <= '0;
        cnt[g] <= '0;
        off[g] <= '0;
      end else if (commit) begin
        acc[g] <= '0;
        cnt[g] <= '0;
        if (cnt[g] != '0) off[g] <= nxt[g];
      end else if (take_ob && in_col == 2'(g) && cnt[g] < CW'(TAKE)) begin
        acc[g] <= acc[g] + AW'(in_dat);
        cnt[g] <= cnt[g] + 1'b1;
      end
    end
  end

  always_comb begin
    case (in_col)
      2'd1:    begin cur_off = off[1]; cur_upd = cnt[1] != '0; end
      2'd2:    begin cur_off = off[2]; cur_upd = cnt[2] != '0; end
      default: begin cur_off = off[0]; cur_upd = cnt[0] != '0; end
    endcase
    if (commit && cur_upd) begin
      case (in_col)
        2'd1:    cur_off = nxt[1];
        2'd2:    cur_off = nxt[2];
        default: cur_off = nxt[0];
      endcase
    end
  end

  assign diff = {1'b0, in_dat} - {1'b0, cur_off};

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      seen    <= 1'b0;
      out_vld <= 1'b0;
      out_col <= 2'd0;
      out_dat <= '0;
    end else begin
      if (commit) seen <= 1'b0;
      else if (take_ob) seen <= 1'b1;
      out_vld <= in_vld && in_act && !in_ob && is_col;
      out_col <= in_col;
      out_dat <= diff[DW] ? '0 : diff[DW-1:0];
    end
  end
endmodule

module ob_offset_corr_chk #(
  parameter int DW = 12
) (
  input logic          clk,
  input logic          rst_n,
  input logic          in_vld,
  input logic [1:0]    in_col,
  input logic          in_ob,
  input logic          in_act,
  input logic [DW-1:0] in_dat,
  input logic          out_vld,
  input logic [1:0]    out_col,
  input logic [DW-1:0] out_dat
);
  p_strobe_r8: assert property (@(posedge clk) disable iff (!rst_n)
    out_vld == $past(in_vld && in_act && !in_ob && in_col != 2'd3));
  p_tag_r9: assert property (@(posedge clk) disable iff (!rst_n)
    out_vld |-> out_col == $past(in_col));
  p_unused_code_r2: assert property (@(posedge clk) disable iff (!rst_n)
    out_vld |-> out_col != 2'd3);
  p_black_silent_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (in_vld && in_ob) |=> !out_vld);
  p_not_above_r7: assert property (@(posedge clk) disable iff (!rst_n)
    out_vld |-> out_dat <= $past(in_dat));
endmodule

bind ob_offset_corr ob_offset_corr_chk #(.DW(DW)) u_chk (.*);

// File: tb/ob_offset_corr_bench.sv
module ob_offset_corr_bench;
  localparam int DW = 12;
  logic clk = 1'b0, rst_n = 1'b0;
  logic in_vld = 0, in_ob = 0, in_act = 0;
  logic [1:0] in_col = 0;
  logic [DW-1:0] in_dat = 0;
  logic a_vld, b_vld;
  logic [1:0] a_col, b_col;
  logic [DW-1:0] a_dat, b_dat;
  int total = 0, bad = 0;
  int sum [2][3], cnt [2][3], off [2][3];
  bit seen [2];
  bit e_vld [2];
  int e_col [2], e_dat [2];

  always #4 clk = ~clk;

  ob_offset_corr u_ob_offset_corr (.clk, .rst_n, .in_vld, .in_col, .in_ob, .in_act, .in_dat,
    .out_vld(a_vld), .out_col(a_col), .out_dat(a_dat));
  ob_offset_corr #(.AVG_MODE(1), .LEAKY(1)) u_ob_offset_corr_b (.clk, .rst_n, .in_vld, .in_col,
    .in_ob, .in_act, .in_dat, .out_vld(b_vld), .out_col(b_col), .out_dat(b_dat));

  initial begin
    #2000000;
    bad++; total++;
    $display("FAIL watchdog: run did not finish");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  function automatic int fdiv8(int d);
    return d >= 0 ? d / 8 : -((-d + 7) / 8);
  endfunction

  task automatic model(int k, bit v, int c, bit ob, bit act, int d);
    int take = (k == 1) ? 32 : 48;
    e_vld[k] = 0;
    if (v && ob && c < 3) begin
      if (cnt[k][c] < take) begin sum[k][c] += d; cnt[k][c]++; end
      seen[k] = 1;
    end else if (v && !ob && seen[k]) begin
      for (int i = 0; i < 3; i++) if (cnt[k][i] > 0) begin  // R6 commit
        int avg = sum[k][i] / take;  // R4 (k=0) / R5 (k=1)
        off[k][i] = (k == 1) ? off[k][i] + fdiv8(avg - off[k][i]) : avg;  // R10
        sum[k][i] = 0; cnt[k][i] = 0;
      end
      seen[k] = 0;
    end
    if (v && !ob && act && c < 3) begin
      e_vld[k] = 1; e_col[k] = c;
      e_dat[k] = (d > off[k][c]) ? d - off[k][c] : 0;  // R7 clamp
    end
  endtask

  task automatic check(int k, logic v, logic [1:0] c, logic [DW-1:0] d);
    total++;
    if (v !== e_vld[k]) begin
      bad++; $display("FAIL R8 inst%0d out_vld=%0b exp=%0b", k, v, e_vld[k]);
    end else if (e_vld[k] && c !== 2'(e_col[k])) begin
      bad++; $display("FAIL R9 inst%0d out_col=%0d exp=%0d", k, c, e_col[k]);
    end else if (e_vld[k] && int'(d) != e_dat[k]) begin
      bad++; $display("FAIL R7/R4/R5/R10 inst%0d out_dat=%0d exp=%0d", k, d, e_dat[k]);
    end
  endtask

  task automatic step(bit v, int c, bit ob, bit act, int d);
    @(negedge clk);
    in_vld = v; in_col = 2'(c); in_ob = ob; in_act = act; in_dat = DW'(d);
    model(0, v, c, ob, act, d);
    model(1, v, c, ob, act, d);
    @(posedge clk); #1;
    check(0, a_vld, a_col, a_dat);
    check(1, b_vld, b_col, b_dat);
  endtask

  // interleaved line: each pixel gives R,G,B; dk = dark level per colour
  task automatic line_il(int dk0, int dk1, int dk2, int nact);
    int dk [3] = '{dk0, dk1, dk2};
    for (int p = 0; p < 48; p++)
      for (int c = 0; c < 3; c++) step(1, c, 1, 0, dk[c] + (p * 7 + c) % 9);
    step(1, 3, 1, 0, 4000);          // R2: unused code in black region
    step(0, 0, 0, 0, 0);
    for (int p = 0; p < 3; p++) for (int c = 0; c < 3; c++) step(1, c, 0, 0, 999);  // R8 dummies
    for (int p = 0; p < nact; p++) begin
      for (int c = 0; c < 3; c++)
        step(1, c, 0, 1, (p % 6 == 0) ? dk[c] / 2 : $urandom_range(4095, 0));
      if (p % 5 == 0) step(1, 3, 0, 1, 1234);  // R2
      if (p % 7 == 0) step(0, 1, 0, 1, 77);
    end
  endtask

  // single-colour line
  task automatic line_mono(int c, int dk, int nact);
    for (int p = 0; p < 50; p++) step(1, c, 1, 0, dk + p % 13);  // R3: 50 > 48
    for (int p = 0; p < nact; p++) begin
      step(1, c, 0, 1, $urandom_range(4095, 0));
      step(1, (c + 1) % 3, 0, 1, $urandom_range(300, 0));  // R6: other colour keeps offset
    end
  endtask

  initial begin
    for (int k = 0; k < 2; k++) begin
      seen[k] = 0;
      for (int c = 0; c < 3; c++) begin sum[k][c] = 0; cnt[k][c] = 0; off[k][c] = 0; end
    end
    repeat (3) @(posedge clk);
    #1;
    total++;  // R1 reset state
    if (a_vld !== 0 || a_dat !== 0 || b_vld !== 0 || b_dat !== 0) begin
      bad++; $display("FAIL R1 reset out a=%0b/%0d b=%0b/%0d exp 0/0", a_vld, a_dat, b_vld, b_dat);
    end
    @(negedge clk); rst_n = 1;
    for (int c = 0; c < 3; c++) step(1, c, 0, 1, 100 + c);  // R1: zero offsets pass through
    line_il(200, 350, 120, 20);
    line_il(260, 300, 500, 20);   // R6: new line offsets used at once
    line_mono(1, 400, 15);
    line_il(60, 900, 4000, 15);   // R7: clamp, large dark
    line_mono(2, 10, 10);
    line_il(3000, 5, 700, 10);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule